// File: doc/BRIEF.md
# Capture Ring Buffer with Fill-Level Interrupts

This block collects incoming audio samples into an on-chip ring buffer. A sample source offers one sample per cycle with a valid strobe. The block stores the sample only while recording is enabled. Before storing, it formats the sample to a selected width and right-justifies it in the entry. A host drains the buffer one entry at a time through a data port. Every strobe on that port advances the read pointer. The write pointer and the read pointer are both visible to the host as entry indices, so software can work out how much data is waiting.

Three sticky status flags drive a single interrupt line:
- a fill-level flag, raised when the buffer fill rises through a programmable fraction of the depth;
- an overrun flag, raised when a sample arrives while the buffer is full;
- an external-event flag, latched from an input pin.

The host clears flags by writing ones. A clear control empties the buffer and drops all flags in one cycle.

Top module: `capbuf_lvl_irq`

## Requirements
- R1: While `buf_clear` is high at a clock edge, both pointers go to 0 and all status bits go to 0 at that edge. This takes priority over every other input.
- R2: A sample is stored only when `smp_valid` and `rec_en` are both high. An accepted sample goes to the write-pointer entry, and the write pointer advances by one modulo DEPTH.
- R3: `smp_data` is 24-bit and MSB-aligned. `fmt_sel` selects the stored width: 00 gives 16 bits, 01 gives 18, 10 gives 20 and 11 gives 24. The stored value is the top N bits of `smp_data`, right-justified and zero-extended, so it equals `smp_data >> (24-N)`.
- R4: When the fill count is non-zero, `rd_data` shows the entry at the read pointer. A `rd_strobe` then advances the read pointer by one modulo DEPTH, so entries come out in write order.
- R5: When the buffer is empty, `rd_data` is 0 and `rd_strobe` leaves the read pointer unchanged.
- R6: `wr_ptr` and `rd_ptr` report entry indices. The fill count is (`wr_ptr` - `rd_ptr`) modulo DEPTH.
- R7: `lvl_sel` sets the level threshold T: 01 gives DEPTH/8, 10 gives DEPTH/4 and 11 gives DEPTH/2.
  - `status[0]` is set when an accepted write with no read in the same cycle takes the fill count from T-1 to T.
  - With code 00, `status[0]` is never set.
- R8: A sample offered while the fill count is DEPTH-1 is dropped. The write pointer does not move, the stored data is unchanged, and `status[1]` is set.
- R9: `status[2]` is set at any edge where `ext_irq_in` is high, and it stays set.
- R10: A 1 in `stat_clr[i]` clears `status[i]`. If a set condition for the same bit occurs in the same cycle, the set wins.
- R11: `irq` is high exactly when one of these holds:
  - `status[0]` is set and `lvl_sel` is non-zero;
  - `status[1]` is set and `ovr_irq_en` is high;
  - `status[2]` is set and `ext_irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rec_en | input | 1 | Recording enable |
| buf_clear | input | 1 | Synchronous clear of pointers and flags |
| fmt_sel | input | 2 | Sample width code |
| lvl_sel | input | 2 | Level threshold code, 00 disables |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| ext_irq_en | input | 1 | External-event interrupt enable |
| ext_irq_in | input | 1 | External event input |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | 24 | MSB-aligned sample |
| rd_strobe | input | 1 | Host read of the data port |
| rd_data | output | 24 | Entry at the read pointer, 0 when empty |
| wr_ptr | output | $clog2(DEPTH) | Write pointer, entry index |
| rd_ptr | output | $clog2(DEPTH) | Read pointer, entry index |
| stat_clr | input | 3 | Write-one-to-clear for the status bits |
| status | output | 3 | {external, overrun, level} flags |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest state to reach is the overrun boundary. The buffer must sit exactly at DEPTH-1 entries, the next sample must be dropped, and nothing already stored may be disturbed. The bench reaches it by building the small 16-entry configuration with no reads, offering one extra sample, and then draining all fifteen entries to prove none were overwritten. The level crossing for each threshold code is approached the same way, one write at a time. The threshold is then crossed a second time from below after some entries are drained, so the test proves the flag fires on the transition and not on the fill level.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

  localparam int SMP_W = 24;

  typedef enum logic [1:0] {
    FMT_16 = 2'b00,
    FMT_18 = 2'b01,
    FMT_20 = 2'b10,
    FMT_24 = 2'b11
  } fmt_e;

  // Top N bits of an MSB-aligned sample, moved to the LSB end.
  function automatic logic [SMP_W-1:0] justify(input logic [SMP_W-1:0] s, input fmt_e f);
    case (f)
      FMT_16:  return {8'd0, s[SMP_W-1:8]};
      FMT_18:  return {6'd0, s[SMP_W-1:6]};
      FMT_20:  return {4'd0, s[SMP_W-1:4]};
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/capbuf_fmt.sv
module capbuf_fmt
  import capbuf_pkg::*;
(
  input  logic [1:0]       fmt_sel,
  input  logic [SMP_W-1:0] smp_in,
  output logic [SMP_W-1:0] smp_out
);

  always_comb begin
    smp_out = justify(smp_in, fmt_e'(fmt_sel));
  end

endmodule

// File: rtl/capbuf_ring.sv
// DEPTH must be a power of two; pointers wrap by natural overflow.
module capbuf_ring #(
  parameter int DEPTH = 1024,
  parameter int W     = 24,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_req,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] fill,
  output logic          wr_acc,
  output logic          wr_drop,
  output logic          rd_acc,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_d, rd_ptr_d;
  logic          full, empty;

  always_comb begin
    fill    = wr_ptr - rd_ptr;
    full    = (fill == PW'(DEPTH-1));
    empty   = (fill == '0);
    wr_acc  = wr_req && !clr && !full;
    wr_drop = wr_req && !clr && full;
    rd_acc  = rd_req && !clr && !empty;
    rd_data = empty ? '0 : mem[rd_ptr];
  end

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (wr_acc) wr_ptr_d = wr_ptr + 1'b1;
      if (rd_acc) rd_ptr_d = rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
    end
  end

  // Storage has no reset; entries are only visible once written.
  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  p_clear_ptrs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wr_ptr == '0) && (rd_ptr == '0));

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !clr && fill == '0) |=> $stable(rd_ptr));

  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !clr && fill == PW'(DEPTH-1)) |=> $stable(wr_ptr));

endmodule

// File: rtl/capbuf_irq.sv
module capbuf_irq #(
  parameter int DEPTH = 1024,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    lvl_sel,
  input  logic          ovr_en,
  input  logic          ext_en,
  input  logic          ext_in,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic          wr_drop,
  input  logic [PW-1:0] fill,
  input  logic [2:0]    stat_clr,
  output logic [2:0]    status,
  output logic          irq
);

  localparam logic [PW-1:0] THR_EIGHTH = PW'(DEPTH / 8);
  localparam logic [PW-1:0] THR_QUART  = PW'(DEPTH / 4);
  localparam logic [PW-1:0] THR_HALF   = PW'(DEPTH / 2);

  logic [PW-1:0] thr;
  logic          lvl_hit;
  logic [2:0]    set_vec, en_vec, status_d;

  always_comb begin
    case (lvl_sel)
      2'b01:   thr = THR_EIGHTH;
      2'b10:   thr = THR_QUART;
      default: thr = THR_HALF;
    endcase
    lvl_hit  = (lvl_sel != 2'b00) && wr_acc && !rd_acc && (fill == thr - 1'b1);
    set_vec  = {ext_in, wr_drop, lvl_hit};
    status_d = clr ? 3'b000 : ((status & ~stat_clr) | set_vec);
    en_vec   = {ext_en, ovr_en, (lvl_sel != 2'b00)};
    irq      = |(status & en_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 3'b000;
    else        status <= status_d;
  end

  p_clear_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status == 3'b000));

  p_ovr_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !clr) |=> status[1]);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_in && stat_clr[2] && !clr) |=> status[2]);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_sel == 2'b00 && !ovr_en && !ext_en) |-> !irq);

endmodule

// File: rtl/capbuf_lvl_irq.sv
module capbuf_lvl_irq
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_en,
  input  logic             buf_clear,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       lvl_sel,
  input  logic             ovr_irq_en,
  input  logic             ext_irq_en,
  input  logic             ext_irq_in,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             rd_strobe,
  output logic [SMP_W-1:0] rd_data,
  output logic [PW-1:0]    wr_ptr,
  output logic [PW-1:0]    rd_ptr,
  input  logic [2:0]       stat_clr,
  output logic [2:0]       status,
  output logic             irq
);

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic [SMP_W-1:0] smp_fmt;
  logic [PW-1:0]    fill;
  logic             wr_acc, wr_drop, rd_acc, wr_req;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign wr_req = smp_valid && rec_en;

  capbuf_fmt u_fmt (
    .fmt_sel (fmt_sel),
    .smp_in  (smp_data),
    .smp_out (smp_fmt)
  );

  capbuf_ring #(.DEPTH(DEPTH), .W(SMP_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (buf_clear),
    .wr_req  (wr_req),
    .wr_data (smp_fmt),
    .rd_req  (rd_strobe),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .fill    (fill),
    .wr_acc  (wr_acc),
    .wr_drop (wr_drop),
    .rd_acc  (rd_acc),
    .rd_data (rd_data)
  );

  capbuf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (buf_clear),
    .lvl_sel  (lvl_sel),
    .ovr_en   (ovr_irq_en),
    .ext_en   (ext_irq_en),
    .ext_in   (ext_irq_in),
    .wr_acc   (wr_acc),
    .rd_acc   (rd_acc),
    .wr_drop  (wr_drop),
    .fill     (fill),
    .stat_clr (stat_clr),
    .status   (status),
    .irq      (irq)
  );

  p_idle_source_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!rec_en && !buf_clear) |=> $stable(wr_ptr));

endmodule

// File: tb/capbuf_lvl_irq_tb.sv
module capbuf_lvl_irq_tb;

  localparam int DEPTH = 16;
  localparam int PW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rec_en, buf_clear, ovr_irq_en, ext_irq_en, ext_irq_in;
  logic          smp_valid, rd_strobe;
  logic [1:0]    fmt_sel, lvl_sel;
  logic [23:0]   smp_data, rd_data;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [2:0]    stat_clr, status;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  capbuf_lvl_irq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .buf_clear(buf_clear),
    .fmt_sel(fmt_sel), .lvl_sel(lvl_sel), .ovr_irq_en(ovr_irq_en),
    .ext_irq_en(ext_irq_en), .ext_irq_in(ext_irq_in), .smp_valid(smp_valid),
    .smp_data(smp_data), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .stat_clr(stat_clr), .status(status),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [23:0] d);
    smp_valid = 1'b1;
    smp_data  = d;
    step();
    smp_valid = 1'b0;
  endtask

  task automatic pop(output logic [23:0] v);
    v = rd_data;
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
  endtask

  task automatic do_clear();
    buf_clear = 1'b1;
    step();
    buf_clear = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [23:0] v;
    logic [23:0] pats [3];
    int t;
    pats[0] = 24'hA5C3F1;
    pats[1] = 24'hFFFFFF;
    pats[2] = 24'h800001;

    rst_n = 1'b0; rec_en = 1'b0; buf_clear = 1'b0; fmt_sel = 2'b11;
    lvl_sel = 2'b00; ovr_irq_en = 1'b0; ext_irq_en = 1'b0; ext_irq_in = 1'b0;
    smp_valid = 1'b0; smp_data = '0; rd_strobe = 1'b0; stat_clr = 3'b000;
    @(negedge clk);
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // reset state
    chk(wr_ptr == 0 && rd_ptr == 0, "R6 reset pointers", {wr_ptr, rd_ptr}, 0);
    chk(status == 0 && irq == 0, "R11 reset flags", {status, irq}, 0);
    chk(rd_data == 0, "R5 reset empty data", rd_data, 0);

    // R2: record disabled ignores samples
    push(24'h123456);
    chk(wr_ptr == 0, "R2 record off ignores sample", wr_ptr, 0);
    chk(rd_data == 0, "R2 record off leaves buffer empty", rd_data, 0);

    // R3: format sweep
    rec_en = 1'b1;
    for (int f = 0; f < 4; f++) begin
      do_clear();
      fmt_sel = 2'(f);
      for (int k = 0; k < 3; k++) push(pats[k]);
      for (int k = 0; k < 3; k++) begin
        t = (f == 3) ? 0 : 8 - 2 * f;
        pop(v);
        chk(v == (pats[k] >> t), "R3 format justify", v, pats[k] >> t);
      end
    end

    // R2 R4 R6: long sweep across pointer wrap
    do_clear();
    fmt_sel = 2'b11;
    for (int i = 0; i < 40; i++) begin
      push(24'(i * 7 + 1));
      chk(wr_ptr == PW'(i + 1), "R2 R6 write pointer wrap", wr_ptr, (i + 1) % DEPTH);
      pop(v);
      chk(v == 24'(i * 7 + 1), "R4 read data order", v, i * 7 + 1);
      chk(rd_ptr == PW'(i + 1), "R4 R6 read pointer wrap", rd_ptr, (i + 1) % DEPTH);
    end

    // R7: level thresholds
    for (int s = 1; s < 4; s++) begin
      do_clear();
      lvl_sel = 2'(s);
      t = DEPTH >> (4 - s);
      for (int k = 0; k < t - 1; k++) push(24'(k));
      chk(status[0] == 1'b0, "R7 below threshold", status[0], 0);
      push(24'h55);
      chk(status[0] == 1'b1, "R7 threshold crossing", status[0], 1);
      chk(irq == 1'b1, "R11 level irq", irq, 1);
      stat_clr = 3'b001;
      step();
      stat_clr = 3'b000;
      chk(status[0] == 1'b0, "R10 level clear", status[0], 0);
      push(24'h66);
      chk(status[0] == 1'b0, "R7 above threshold no refire", status[0], 0);
      pop(v);
      pop(v);
      push(24'h77);
      chk(status[0] == 1'b1, "R7 second upward crossing", status[0], 1);
    end
    do_clear();
    lvl_sel = 2'b00;
    for (int k = 0; k < 10; k++) push(24'(k));
    chk(status[0] == 1'b0 && irq == 1'b0, "R7 code 00 disabled", {status[0], irq}, 0);

    // R8: overrun
    do_clear();
    for (int k = 0; k < DEPTH - 1; k++) push(24'(100 + k));
    chk(status[1] == 1'b0, "R8 no overrun at DEPTH-1", status[1], 0);
    push(24'h999);
    chk(wr_ptr == PW'(DEPTH - 1), "R8 pointer holds on drop", wr_ptr, DEPTH - 1);
    chk(status[1] == 1'b1, "R8 overrun flag", status[1], 1);
    chk(irq == 1'b0, "R11 overrun masked", irq, 0);
    ovr_irq_en = 1'b1;
    #1;
    chk(irq == 1'b1, "R11 overrun enabled", irq, 1);
    ovr_irq_en = 1'b0;
    for (int k = 0; k < DEPTH - 1; k++) begin
      pop(v);
      chk(v == 24'(100 + k), "R8 stored data intact", v, 100 + k);
    end

    // R5: empty read
    chk(rd_data == 0, "R5 empty data zero", rd_data, 0);
    pop(v);
    chk(rd_ptr == PW'(DEPTH - 1), "R5 empty read holds pointer", rd_ptr, DEPTH - 1);

    // R9 R10 R11: external flag
    ext_irq_in = 1'b1;
    step();
    ext_irq_in = 1'b0;
    step();
    chk(status[2] == 1'b1, "R9 external sticky", status[2], 1);
    chk(irq == 1'b0, "R11 external masked", irq, 0);
    ext_irq_en = 1'b1;
    #1;
    chk(irq == 1'b1, "R11 external enabled", irq, 1);
    ext_irq_in = 1'b1;
    stat_clr = 3'b100;
    step();
    chk(status[2] == 1'b1, "R10 set wins over clear", status[2], 1);
    ext_irq_in = 1'b0;
    step();
    stat_clr = 3'b000;
    chk(status[2] == 1'b0, "R10 external clear", status[2], 0);

    // R1: clear with flags pending
    ext_irq_in = 1'b1;
    step();
    ext_irq_in = 1'b0;
    push(24'h42);
    push(24'h43);
    do_clear();
    chk(wr_ptr == 0 && rd_ptr == 0, "R1 clear pointers", {wr_ptr, rd_ptr}, 0);
    chk(status == 0, "R1 clear flags", status, 0);

    done = 1'b1;
    finish_run();
  end

endmodule